// File: doc/BRIEF.md
# Variant-Masked Watchdog Timer

This block is a countdown watchdog with a small bank of 32-bit registers behind a word-addressed write port and a combinational read port. Software programs a reload value, then enables the timer through the control register. While enabled, the counter steps down on an external tick strobe. A timeout fires when the count runs out. Software prevents the timeout by writing a fixed key to the restart register, which reloads the counter.

A static parameter selects one of three hardware variants. Every write to the control register passes through that variant's mask first, and so does the register's reset value. A mask can clear reserved fields or hold the fast-clock select high. The stored value and the enable decision both come from the masked value. The timeout output is a single-cycle request meant for a system reset controller.

Top module: `wdog_core`

## Requirements
- R1: A register is selected by byte address bits [4:2]. Index 0 is the live count (read-only, writes have no effect), 1 is the reload value, 2 is restart (reads 0), 3 is control and 4 is the reset width. Indices 5 to 7, and any access with address bits [1:0] not zero, read 0 and writes to them have no effect.
- R2: After reset the count and the reload value read 0x03EF1480, restart reads 0, the reset width reads 0x000000FF and timeout is low.
- R3: With VARIANT 0, a control write stores only bits 15:0 and bits 31:16 read as zero.
- R4: With VARIANT 1, a control write stores bits 11:8 as zero and bit 4 as one, whatever was written. All other bits are kept.
- R5: With VARIANT 2, a control write stores bits 9:7 as zero and keeps all other bits.
- R6: The control register resets to the variant's mask applied to zero: 0x00000010 for VARIANT 1 and 0 for the others.
- R7: A control write whose masked bit 0 (enable) is 1 while the stored enable is 0 loads the count from the reload register. A control write made while already enabled does not reload.
- R8: While enabled, the count decrements once per tick_fast strobe when control bit 4 is 1, and once per tick_slow strobe when it is 0. While disabled, the count holds. Enable and select take effect on the cycle after the control write.
- R9: A restart write of exactly 0x00004755 while enabled loads the count from the reload register. Any other value, or the key written while disabled, leaves the count unchanged.
- R10: A selected tick that finds the count at 1 or 0 loads the count from the reload register and raises timeout for exactly that one cycle.
- R11: A reload from a restart or an enabling control write takes priority over a tick in the same cycle. That tick neither decrements nor raises timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 5 | Byte address of the register to read or write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tick_fast | input | 1 | Fast time-base strobe (1 MHz) |
| tick_slow | input | 1 | Slow time-base strobe |
| timeout | output | 1 | One-cycle timeout request |

## Verification
The collision that matters is a reload meeting a countdown tick in the same cycle. This happens when a keyed restart or an enabling control write lands on a cycle that also carries a tick, possibly the tick that would have expired the count. The bench provokes it by running both tick strobes on every cycle with a small reload value while restarts keep arriving. It judges the result by comparing the live count and the timeout output on every clock against a behavioural model in which the reload wins. Three instances, one per variant, share the same stimulus. Writing the slow-select encoding then shows both the forced select bit in variant 1 and the selected tick source.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned WDOG_DW = 32;

   typedef enum logic [2:0] {
      IDX_COUNT   = 3'd0,
      IDX_RELOAD  = 3'd1,
      IDX_RESTART = 3'd2,
      IDX_CTRL    = 3'd3,
      IDX_WIDTH   = 3'd4
   } wdog_idx_e;

   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned CTRL_FAST_BIT = 4;

   localparam logic [WDOG_DW-1:0] RESTART_KEY = 32'h0000_4755;
   localparam logic [WDOG_DW-1:0] COUNT_RST   = 32'h03EF_1480;
   localparam logic [WDOG_DW-1:0] WIDTH_RST   = 32'h0000_00FF;
endpackage

// File: rtl/wdog_ctrl_mask.sv
module wdog_ctrl_mask
   import wdog_pkg::*;
#(
   parameter int unsigned VARIANT = 1,
   parameter int unsigned DW      = WDOG_DW
) (
   input  logic [DW-1:0] raw,
   output logic [DW-1:0] clean
);
   localparam logic [DW-1:0] LOW_HALF  = {{(DW-16){1'b0}}, 16'hFFFF};
   localparam logic [DW-1:0] V1_CLEAR  = DW'(4'hF) << 8;
   localparam logic [DW-1:0] V1_FORCE  = DW'(1) << CTRL_FAST_BIT;
   localparam logic [DW-1:0] V2_CLEAR  = DW'(3'h7) << 7;

   initial assert (VARIANT <= 2 && DW >= 16)
      else $error("wdog_ctrl_mask: unsupported VARIANT or DW");

   generate
      if (VARIANT == 0) begin : g_v0
         assign clean = raw & LOW_HALF;
      end else if (VARIANT == 1) begin : g_v1
         assign clean = (raw & ~V1_CLEAR) | V1_FORCE;
      end else begin : g_v2
         assign clean = raw & ~V2_CLEAR;
      end
   endgenerate
endmodule

// File: rtl/wdog_regfile.sv
module wdog_regfile
   import wdog_pkg::*;
#(
   parameter int unsigned VARIANT = 1,
   parameter int unsigned DW      = WDOG_DW,
   parameter int unsigned AW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] count,
   output logic [DW-1:0] rdata,
   output logic [DW-1:0] ctrl_q,
   output logic [DW-1:0] reload_q,
   output logic          load_req
);
   localparam int unsigned IW = AW - 2;

   initial assert (AW >= 5 && DW == WDOG_DW)
      else $error("wdog_regfile: AW must be at least 5 and DW 32");

   logic [IW-1:0] idx;
   logic          aligned;
   logic [DW-1:0] width_q;
   logic [DW-1:0] wr_clean;
   logic [DW-1:0] rst_clean;
   logic          sel_reload, sel_restart, sel_ctrl, sel_width;
   logic          en_now;

   assign idx     = addr[AW-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign en_now  = ctrl_q[CTRL_EN_BIT];

   assign sel_reload  = wr && aligned && (idx == IW'(IDX_RELOAD));
   assign sel_restart = wr && aligned && (idx == IW'(IDX_RESTART));
   assign sel_ctrl    = wr && aligned && (idx == IW'(IDX_CTRL));
   assign sel_width   = wr && aligned && (idx == IW'(IDX_WIDTH));

   wdog_ctrl_mask #(.VARIANT(VARIANT), .DW(DW)) u_wr_mask (
      .raw   (wdata),
      .clean (wr_clean)
   );

   wdog_ctrl_mask #(.VARIANT(VARIANT), .DW(DW)) u_rst_mask (
      .raw   ('0),
      .clean (rst_clean)
   );

   always_comb begin
      load_req = 1'b0;
      if (sel_ctrl && wr_clean[CTRL_EN_BIT] && !en_now)
         load_req = 1'b1;
      if (sel_restart && (wdata == RESTART_KEY) && en_now)
         load_req = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= rst_clean;
         reload_q <= COUNT_RST;
         width_q  <= WIDTH_RST;
      end else begin
         if (sel_ctrl)   ctrl_q   <= wr_clean;
         if (sel_reload) reload_q <= wdata;
         if (sel_width)  width_q  <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (aligned) begin
         case (idx)
            IW'(IDX_COUNT):  rdata = count;
            IW'(IDX_RELOAD): rdata = reload_q;
            IW'(IDX_CTRL):   rdata = ctrl_q;
            IW'(IDX_WIDTH):  rdata = width_q;
            default:         rdata = '0;
         endcase
      end
   end

   generate
      if (VARIANT == 0) begin : g_chk_v0
         p_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_q[DW-1:16] == '0);
      end else if (VARIANT == 1) begin : g_chk_v1
         p_fast_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_q[CTRL_FAST_BIT] && (ctrl_q[11:8] == 4'h0));
      end else begin : g_chk_v2
         p_mid_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_q[9:7] == 3'h0);
      end
   endgenerate

   p_reload_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_reload |=> reload_q == $past(reload_q));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
   import wdog_pkg::*;
#(
   parameter int unsigned DW = WDOG_DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          fast_sel,
   input  logic          tick_fast,
   input  logic          tick_slow,
   input  logic          load_req,
   input  logic [DW-1:0] reload_val,
   output logic [DW-1:0] count,
   output logic          timeout
);
   logic tick;
   logic step;
   logic expire;

   assign tick   = fast_sel ? tick_fast : tick_slow;
   assign step   = enable && tick && !load_req;
   assign expire = (count <= DW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= COUNT_RST;
         timeout <= 1'b0;
      end else begin
         timeout <= 1'b0;
         if (load_req) begin
            count <= reload_val;
         end else if (step) begin
            if (expire) begin
               count   <= reload_val;
               timeout <= 1'b1;
            end else begin
               count <= count - DW'(1);
            end
         end
      end
   end

   p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !load_req) |=> $stable(count));

   p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      load_req |=> (count == $past(reload_val)) && !timeout);

   p_timeout_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> (count == $past(reload_val)) && $past(enable));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
   import wdog_pkg::*;
#(
   parameter int unsigned VARIANT = 1,
   parameter int unsigned AW      = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          tick_fast,
   input  logic          tick_slow,
   output logic          timeout
);
   localparam int unsigned DW = WDOG_DW;

   logic [DW-1:0] ctrl_q;
   logic [DW-1:0] reload_q;
   logic [DW-1:0] count;
   logic          load_req;

   wdog_regfile #(.VARIANT(VARIANT), .DW(DW), .AW(AW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .count    (count),
      .rdata    (reg_rdata),
      .ctrl_q   (ctrl_q),
      .reload_q (reload_q),
      .load_req (load_req)
   );

   wdog_counter #(.DW(DW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (ctrl_q[CTRL_EN_BIT]),
      .fast_sel   (ctrl_q[CTRL_FAST_BIT]),
      .tick_fast  (tick_fast),
      .tick_slow  (tick_slow),
      .load_req   (load_req),
      .reload_val (reload_q),
      .count      (count),
      .timeout    (timeout)
   );

   p_no_pulse_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CTRL_EN_BIT] |=> !timeout);
endmodule

// File: tb/wdog_core_bench.sv
module wdog_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [4:0]  addr = 5'd0;
   logic [31:0] wdata = 32'd0;
   logic        tick_f = 1'b0;
   logic        tick_s = 1'b0;
   logic [31:0] rd [3];
   logic        tmo [3];

   int compared = 0;
   int mismatched = 0;
   int fast_per = 0;
   int slow_per = 0;
   int cyc = 0;
   bit started = 1'b0;
   string phase = "R2";

   always #4 clk = ~clk;

   wdog_core #(.VARIANT(0)) u_wdog_core_v0 (.clk(clk), .rst_n(rst_n), .reg_wr(wr),
      .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rd[0]),
      .tick_fast(tick_f), .tick_slow(tick_s), .timeout(tmo[0]));
   wdog_core u_wdog_core (.clk(clk), .rst_n(rst_n), .reg_wr(wr),
      .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rd[1]),
      .tick_fast(tick_f), .tick_slow(tick_s), .timeout(tmo[1]));
   wdog_core #(.VARIANT(2)) u_wdog_core_v2 (.clk(clk), .rst_n(rst_n), .reg_wr(wr),
      .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rd[2]),
      .tick_fast(tick_f), .tick_slow(tick_s), .timeout(tmo[2]));

   // behavioural reference
   logic [31:0] m_ctrl [3];
   logic [31:0] m_cnt  [3];
   logic [31:0] m_rld  [3];
   logic [31:0] m_wid  [3];
   logic        m_tmo  [3];

   function automatic logic [31:0] vmask(int v, logic [31:0] d);
      if (v == 0) return d & 32'h0000_FFFF;
      if (v == 1) return (d & ~32'h0000_0F00) | 32'h0000_0010;
      return d & ~32'h0000_0380;
   endfunction

   function automatic logic [31:0] exp_rd(int v, logic [4:0] a);
      if (a[1:0] != 2'b00) return 32'd0;
      case (a[4:2])
         3'd0: return m_cnt[v];
         3'd1: return m_rld[v];
         3'd3: return m_ctrl[v];
         3'd4: return m_wid[v];
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk) begin
      for (int v = 0; v < 3; v++) begin
         if (!rst_n) begin
            m_ctrl[v] = vmask(v, 32'd0);
            m_cnt[v]  = 32'h03EF_1480;
            m_rld[v]  = 32'h03EF_1480;
            m_wid[v]  = 32'h0000_00FF;
            m_tmo[v]  = 1'b0;
         end else begin
            automatic logic en = m_ctrl[v][0];
            automatic logic tk = m_ctrl[v][4] ? tick_f : tick_s;
            automatic logic [31:0] old_rld = m_rld[v];
            automatic logic ld = 1'b0;
            automatic logic [31:0] mm;
            m_tmo[v] = 1'b0;
            if (wr && addr[1:0] == 2'b00) begin
               case (addr[4:2])
                  3'd1: m_rld[v] = wdata;
                  3'd2: if (wdata == 32'h4755 && en) begin m_cnt[v] = old_rld; ld = 1'b1; end
                  3'd3: begin
                     mm = vmask(v, wdata);
                     if (mm[0] && !en) begin m_cnt[v] = old_rld; ld = 1'b1; end
                     m_ctrl[v] = mm;
                  end
                  3'd4: m_wid[v] = wdata;
                  default: ;
               endcase
            end
            if (!ld && en && tk) begin
               if (m_cnt[v] <= 32'd1) begin
                  m_cnt[v] = old_rld;
                  m_tmo[v] = 1'b1;
               end else begin
                  m_cnt[v] = m_cnt[v] - 32'd1;
               end
            end
         end
      end
      started = 1'b1;
   end

   // per-cycle comparison, away from both edges
   always @(posedge clk) begin
      #2;
      if (started) begin
         for (int v = 0; v < 3; v++) begin
            compared++;
            if (rd[v] !== exp_rd(v, addr)) begin
               mismatched++;
               $display("FAIL %s variant %0d addr 0x%0h: rdata actual 0x%08h expected 0x%08h",
                        phase, v, addr, rd[v], exp_rd(v, addr));
            end
            compared++;
            if (tmo[v] !== m_tmo[v]) begin
               mismatched++;
               $display("FAIL R10 (%s) variant %0d: timeout actual %0b expected %0b",
                        phase, v, tmo[v], m_tmo[v]);
            end
         end
      end
   end

   // tick strobes
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         tick_f = (fast_per > 0) && (cyc % fast_per == 0);
         tick_s = (slow_per > 0) && (cyc % slow_per == 0);
      end
   end

   task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic look(input logic [4:0] a, input int n);
      @(negedge clk);
      addr = a;
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: run hung, actual running expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2 reset values, R6 control reset value
      phase = "R2";
      look(5'd0, 2); look(5'd4, 2); look(5'd8, 2); look(5'd16, 2);
      phase = "R6";
      look(5'd12, 2);
      // R1 decode, unused and misaligned slots
      phase = "R1";
      look(5'd20, 1); look(5'd24, 1); look(5'd28, 1); look(5'd13, 1);
      wr_reg(5'd0, 32'h55);
      wr_reg(5'd13, 32'h1);
      wr_reg(5'd24, 32'h1234);
      look(5'd12, 2); look(5'd0, 2);
      wr_reg(5'd16, 32'h1234);
      look(5'd16, 2);
      // R3 R4 R5 masking of disabled writes
      phase = "R3";
      wr_reg(5'd12, 32'hFFFF_FFFE); look(5'd12, 2);
      phase = "R4";
      wr_reg(5'd12, 32'h0000_0000); look(5'd12, 2);
      phase = "R5";
      wr_reg(5'd12, 32'hAAAA_5A5A); look(5'd12, 2);
      wr_reg(5'd12, 32'h0000_0F80); look(5'd12, 2);
      // R7 enable edge reloads, enabled rewrite does not
      phase = "R7";
      wr_reg(5'd4, 32'd20);
      wr_reg(5'd12, 32'h11);
      look(5'd0, 4);
      fast_per = 2;
      look(5'd0, 6);
      wr_reg(5'd12, 32'h11);
      look(5'd0, 4);
      // R8 tick selection and hold while disabled
      phase = "R8";
      fast_per = 0; slow_per = 3;
      look(5'd0, 8);
      wr_reg(5'd12, 32'h10);
      fast_per = 1; slow_per = 1;
      look(5'd0, 6);
      fast_per = 0; slow_per = 0;
      wr_reg(5'd4, 32'd30);
      wr_reg(5'd12, 32'h01);
      fast_per = 2; slow_per = 3;
      look(5'd0, 12);
      // R10 expiry and reload
      phase = "R10";
      wr_reg(5'd4, 32'd3);
      wr_reg(5'd8, 32'h4755);
      fast_per = 1; slow_per = 1;
      look(5'd0, 30);
      wr_reg(5'd4, 32'd0);
      look(5'd0, 6);
      // R9 restart key
      phase = "R9";
      fast_per = 0; slow_per = 0;
      wr_reg(5'd4, 32'd9);
      look(5'd0, 2);
      wr_reg(5'd8, 32'h4756);
      look(5'd0, 2);
      wr_reg(5'd8, 32'h4755);
      look(5'd0, 2);
      wr_reg(5'd12, 32'h0);
      wr_reg(5'd4, 32'd12);
      wr_reg(5'd8, 32'h4755);
      look(5'd0, 2);
      look(5'd8, 2);
      // R11 reload beats coincident tick
      phase = "R11";
      wr_reg(5'd4, 32'd4);
      fast_per = 1; slow_per = 1;
      wr_reg(5'd12, 32'h11);
      for (int k = 0; k < 8; k++) begin
         wr_reg(5'd8, 32'h4755);
         look(5'd0, 1);
      end
      wr_reg(5'd12, 32'h10);
      wr_reg(5'd12, 32'h01);
      look(5'd0, 10);
      fast_per = 0; slow_per = 0;
      look(5'd0, 2);
      finish_run();
   end
endmodule